// File: doc/BRIEF.md
# Cross-Domain Register Write Synchronizer

This block moves register writes from a peripheral bus clock domain into a separate generic clock domain. It keeps a bus-side shadow copy of every synchronized register and hands each write across with a toggle request and acknowledge. Each register has its own handshake channel. While a register's transfer is in flight, its sync-busy flag is high, and any bus access to that register is held off with wait states. The status word and unmapped addresses never wait.

Register 0 is the control register. Bit 0 requests a software reset and bit 1 is the peripheral enable. A software reset travels the same handshake. When it reaches the generic domain it zeroes every generic-domain register. Once the acknowledge returns, the bus side clears all shadows and the busy flag in the same bus edge, so the request bit clears itself. The sync-busy flag is the only completion indication for a software reset.

The bus side uses an APB-style two-phase access: a setup cycle followed by an access cycle. The access cycle ends on the first rising edge at which `pready` is high.

Top module: `xws_bridge`

## Requirements
- R1: After reset, `pready` is 1, `sync_busy` is 0, `g_regs` and `g_enable` are 0, and every register reads 0.
- R2: A read of the status address (index NREG, bit i = `sync_busy[i]`) takes two bus cycles, setup and access, with no wait state. So does any access to a register that is not busy and not blocked by a pending reset.
- R3: The bus edge that accepts a write to register i sets `sync_busy[i]`.
- R4: Let D be the time from the accepting edge to the fall of `sync_busy[i]`. With bus period Pb and generic period Pg, D satisfies 5·Pg + 2·Pb < D ≤ 6·Pg + 3·Pb.
- R5: A read or write of register i while `sync_busy[i]` is 1 keeps `pready` low until the flag clears, and then completes. A held write is launched exactly once.
- R6: Once `sync_busy[i]` has cleared, slice i of `g_regs` holds the written value. Register i reads back the written value.
- R7: `g_enable` equals bit 1 of the generic-domain copy of the control register.
- R8: A control write with bit 0 = 0 starts no reset. The other generic registers keep their values, and the control register reads back the written value.
- R9: A control write with bit 0 = 1 discards its other bits and keeps `sync_busy[0]` high until the generic-domain reset is done. After that, every register reads 0 and `g_regs` and `g_enable` are 0.
- R10: While a software reset is pending, accesses to any register stall. The status word stays readable without wait states.
- R11: If a data-register write is still in flight when a software reset is launched, every register ends at 0, including when both reach the generic domain in the same cycle.
- R12: Addresses above NREG read 0, ignore writes, and never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Peripheral bus clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| psel | input | 1 | Access select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Register index; NREG is the status word |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data |
| pready | output | 1 | Low inserts a wait state |
| sync_busy | output | NREG | Per-register transfer in flight |
| gclk | input | 1 | Generic clock |
| gclk_rst_n | input | 1 | Generic-domain asynchronous reset, active low |
| g_regs | output | NREG*DW | Generic-domain register copies, register i at bits i*DW +: DW |
| g_enable | output | 1 | Generic-domain enable |

## Verification
Two functions can land in the same generic clock cycle: the arrival of a data-register write and the arrival of a software reset launched two bus cycles later. The bench provokes this by issuing the data write and then, back to back, the reset write. It repeats that pair under several generic clock periods unrelated to the bus period, so the two arrivals fall sometimes in the same generic cycle and sometimes in adjacent ones. In every case it judges the outcome at the ports: all register readbacks and all generic copies must be zero, so the reset wins regardless of arrival order.

// File: rtl/xws_pkg.sv
`timescale 1ns/1ps
package xws_pkg;
  localparam int CTRL_IDX   = 0;
  localparam int SWRST_BIT  = 0;
  localparam int ENABLE_BIT = 1;

  // generic-clock cycles between request toggle and acknowledge toggle
  function automatic int gclk_lag(input int sync_stages, input int settle);
    return sync_stages + 1 + settle;
  endfunction
endpackage

// File: rtl/xws_sync.sv
`timescale 1ns/1ps
module xws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= STAGES'({ff, d});
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/xws_chan.sv
`timescale 1ns/1ps
module xws_chan #(
  parameter int SYNC_STAGES = 2,
  parameter int G_SETTLE    = 3
) (
  input  logic bus_clk,
  input  logic bus_rst_n,
  input  logic launch,
  output logic busy,
  output logic done,
  input  logic gclk,
  input  logic gclk_rst_n,
  output logic g_apply
);
  logic req_q, ack_s, ack_seen_q;
  logic g_req_s, g_req_q, g_ack;

  // bus side: request toggle and acknowledge capture
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      if (launch) req_q <= ~req_q;
      ack_seen_q <= ack_s;
    end
  end

  xws_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(g_ack), .q(ack_s)
  );

  assign busy = req_q ^ ack_seen_q;
  assign done = ack_s ^ ack_seen_q;

  // generic side: request capture, apply pulse, settle chain
  xws_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(gclk), .rst_n(gclk_rst_n), .d(req_q), .q(g_req_s)
  );

  always_ff @(posedge gclk or negedge gclk_rst_n) begin
    if (!gclk_rst_n) g_req_q <= 1'b0;
    else             g_req_q <= g_req_s;
  end

  assign g_apply = g_req_s ^ g_req_q;

  generate
    if (G_SETTLE == 0) begin : g_no_settle
      assign g_ack = g_req_q;
    end else begin : g_settle
      logic [G_SETTLE-1:0] chain;
      always_ff @(posedge gclk or negedge gclk_rst_n) begin
        if (!gclk_rst_n) chain <= '0;
        else             chain <= G_SETTLE'({chain, g_req_q});
      end
      assign g_ack = chain[G_SETTLE-1];
    end
  endgenerate
endmodule

// File: rtl/xws_bridge.sv
`timescale 1ns/1ps
module xws_bridge
  import xws_pkg::*;
#(
  parameter int NREG        = 3,
  parameter int DW          = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int G_SETTLE    = 3
) (
  input  logic                 bus_clk,
  input  logic                 bus_rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DW-1:0]        pwdata,
  output logic [DW-1:0]        prdata,
  output logic                 pready,
  output logic [NREG-1:0]      sync_busy,
  input  logic                 gclk,
  input  logic                 gclk_rst_n,
  output logic [NREG*DW-1:0]   g_regs,
  output logic                 g_enable
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NREG);

  logic              access, hit_reg, hit_stat, stall;
  logic              swrst_pend, swrst_done;
  logic [NREG-1:0]   addr_hit, launch, done, g_apply;
  logic [DW-1:0]     shadow [NREG];
  logic [DW-1:0]     g_copy [NREG];

  // a reset request discards the rest of the control word
  function automatic logic [DW-1:0] ctrl_commit(input logic [DW-1:0] w);
    logic [DW-1:0] only_rst;
    only_rst = '0;
    only_rst[SWRST_BIT] = 1'b1;
    return w[SWRST_BIT] ? only_rst : w;
  endfunction

  assign access   = psel & penable;
  assign hit_reg  = paddr < STAT_ADDR;
  assign hit_stat = paddr == STAT_ADDR;

  assign swrst_pend = shadow[CTRL_IDX][SWRST_BIT];
  assign swrst_done = swrst_pend & done[CTRL_IDX];

  assign stall  = access & hit_reg & ((|(addr_hit & sync_busy)) | swrst_pend);
  assign pready = ~stall;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_chan
      assign addr_hit[i] = paddr == ADDR_W'(i);
      assign launch[i]   = access & pwrite & ~stall & addr_hit[i];

      xws_chan #(.SYNC_STAGES(SYNC_STAGES), .G_SETTLE(G_SETTLE)) u_chan (
        .bus_clk   (bus_clk),
        .bus_rst_n (bus_rst_n),
        .launch    (launch[i]),
        .busy      (sync_busy[i]),
        .done      (done[i]),
        .gclk      (gclk),
        .gclk_rst_n(gclk_rst_n),
        .g_apply   (g_apply[i])
      );

      assign g_regs[i*DW +: DW] = g_copy[i];
    end
  endgenerate

  // bus-side shadows, also the stable source of the crossing data
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else if (swrst_done) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (launch[i]) shadow[i] <= (i == CTRL_IDX) ? ctrl_commit(pwdata) : pwdata;
    end
  end

  always_comb begin
    prdata = '0;
    for (int i = 0; i < NREG; i++)
      if (addr_hit[i]) prdata = shadow[i];
    if (hit_stat) prdata = DW'(sync_busy);
  end

  // generic-domain copies; reset wins over any same-cycle data arrival
  always_ff @(posedge gclk or negedge gclk_rst_n) begin
    if (!gclk_rst_n) begin
      for (int i = 0; i < NREG; i++) g_copy[i] <= '0;
    end else if (g_apply[CTRL_IDX] && swrst_pend) begin
      for (int i = 0; i < NREG; i++) g_copy[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (g_apply[i]) g_copy[i] <= shadow[i];
    end
  end

  assign g_enable = g_copy[CTRL_IDX][ENABLE_BIT];
endmodule

// File: rtl/xws_chk.sv
`timescale 1ns/1ps
module xws_chk #(
  parameter int NREG   = 3,
  parameter int DW     = 8,
  parameter int ADDR_W = 3
) (
  input logic                bus_clk,
  input logic                bus_rst_n,
  input logic                gclk,
  input logic                gclk_rst_n,
  input logic                psel,
  input logic                penable,
  input logic [ADDR_W-1:0]   paddr,
  input logic                wr_rst_bit,
  input logic                pready,
  input logic [NREG-1:0]     sync_busy,
  input logic [NREG*DW-1:0]  g_regs,
  input logic [NREG-1:0]     launch,
  input logic                done_ctrl,
  input logic                g_apply_ctrl,
  input logic                swrst_pend
);
  for (genvar i = 0; i < NREG; i++) begin : g_ch
    AST_NO_DOUBLE_LAUNCH: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      launch[i] |-> !sync_busy[i]); // R5
    AST_BUSY_AFTER_LAUNCH: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      launch[i] |=> sync_busy[i]); // R3
    AST_STALL_WHILE_BUSY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (psel && penable && paddr == ADDR_W'(i) && sync_busy[i]) |-> !pready); // R5
  end

  AST_STATUS_NO_WAIT: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (psel && penable && paddr >= ADDR_W'(NREG)) |-> pready); // R2
  AST_ZERO_NO_RESET: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (launch[0] && !wr_rst_bit) |=> !swrst_pend); // R8
  AST_RESET_HELD: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (swrst_pend && !done_ctrl) |=> swrst_pend); // R9
  AST_RESET_STALLS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (swrst_pend && psel && penable && paddr < ADDR_W'(NREG)) |-> !pready); // R10
  AST_RESET_CLEARS: assert property (@(posedge gclk) disable iff (!gclk_rst_n)
    (g_apply_ctrl && swrst_pend) |=> (g_regs == '0)); // R11
endmodule

bind xws_bridge xws_chk #(.NREG(NREG), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .bus_clk     (bus_clk),
  .bus_rst_n   (bus_rst_n),
  .gclk        (gclk),
  .gclk_rst_n  (gclk_rst_n),
  .psel        (psel),
  .penable     (penable),
  .paddr       (paddr),
  .wr_rst_bit  (pwdata[0]),
  .pready      (pready),
  .sync_busy   (sync_busy),
  .g_regs      (g_regs),
  .launch      (launch),
  .done_ctrl   (done[0]),
  .g_apply_ctrl(g_apply[0]),
  .swrst_pend  (swrst_pend)
);

// File: tb/xws_bridge_tb_top.sv
`timescale 1ns/1ps
module xws_bridge_tb_top;
  localparam int  NREG = 3;
  localparam int  DW   = 8;
  localparam int  AW   = 3;
  localparam real PB   = 8.0;

  logic bus_clk = 1'b0, gclk = 1'b0;
  logic bus_rst_n = 1'b0, gclk_rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic pready, g_enable;
  logic [NREG-1:0] sync_busy;
  logic [NREG*DW-1:0] g_regs;

  real g_half = 6.85;
  int  n_chk = 0, n_bad = 0;
  logic [DW-1:0] exp_g [NREG];
  real periods [4] = '{2.65, 5.85, 11.95, 18.55};

  always #4 bus_clk = ~bus_clk;
  always #(g_half) gclk = ~gclk;

  xws_bridge dut_i (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .sync_busy(sync_busy), .gclk(gclk), .gclk_rst_n(gclk_rst_n),
    .g_regs(g_regs), .g_enable(g_enable)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int waits, output realtime t_acc);
    @(negedge bus_clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge bus_clk);
    penable = 1'b1;
    #1;
    waits = 0;
    while (!pready) begin
      @(negedge bus_clk); #1; waits++;
    end
    rd = prdata;
    @(posedge bus_clk);
    t_acc = $realtime;
    #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wait_idle(input int i, output realtime t);
    while (sync_busy[i]) @(sync_busy[i]);
    t = $realtime;
  endtask

  task automatic check_delay(input realtime t0, input realtime t1, input string tag);
    real pg, d, lo, hi;
    pg = 2.0 * g_half;
    d  = t1 - t0;
    lo = 5.0 * pg + 2.0 * PB;
    hi = 6.0 * pg + 3.0 * PB;
    n_chk++;
    if (!(d > lo - 0.01 && d < hi + 0.01)) begin
      n_bad++;
      $display("FAIL R4 %s: actual delay=%f expected range (%f, %f]", tag, d, lo, hi);
    end
  endtask

  function automatic logic [NREG*DW-1:0] pack_exp();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = exp_g[i];
    return v;
  endfunction

  initial begin
    logic [DW-1:0] rd, v;
    int w;
    realtime ta, tb;
    for (int i = 0; i < NREG; i++) exp_g[i] = '0;
    repeat (5) @(negedge bus_clk);
    bus_rst_n = 1'b1; gclk_rst_n = 1'b1;
    #1;
    // R1 reset state
    check(pready == 1'b1, "R1", "pready", pready, 1);
    check(sync_busy == '0, "R1", "sync_busy", sync_busy, 0);
    check(g_regs == '0 && g_enable == 1'b0, "R1", "g_regs", g_regs, 0);
    for (int i = 0; i < NREG; i++) begin
      bus_xfer(1'b0, AW'(i), '0, rd, w, ta);
      check(rd == '0 && w == 0, "R1", "reset readback", rd, 0);
    end
    // R2 status word, R12 unmapped addresses
    bus_xfer(1'b0, AW'(NREG), '0, rd, w, ta);
    check(rd == '0 && w == 0, "R2", "status read", {rd, 8'(w)}, 0);
    bus_xfer(1'b1, 3'd5, 8'hFF, rd, w, ta);
    check(w == 0, "R12", "unmapped write waits", w, 0);
    bus_xfer(1'b0, 3'd5, '0, rd, w, ta);
    check(rd == '0 && w == 0, "R12", "unmapped read", rd, 0);
    bus_xfer(1'b0, AW'(NREG), '0, rd, w, ta);
    check(rd == '0 && g_regs == pack_exp(), "R12", "no side effect", g_regs, pack_exp());

    // sweep over generic periods, registers and idle gaps: R3 R4 R6 R7 R8
    foreach (periods[p]) begin
      g_half = periods[p];
      repeat (4) @(negedge bus_clk);
      for (int i = 0; i < NREG; i++) begin
        for (int k = 0; k < 3; k++) begin
          repeat (k) @(negedge bus_clk);
          v = 8'((i * 37 + k * 11 + p * 73 + 5) & 255);
          if (i == 0) v = v & 8'hFE;
          bus_xfer(1'b1, AW'(i), v, rd, w, ta);
          check(w == 0, "R2", "idle write waits", w, 0);
          check(sync_busy[i] == 1'b1, "R3", "busy after write", sync_busy[i], 1);
          wait_idle(i, tb);
          check_delay(ta, tb, "sweep");
          exp_g[i] = v;
          #1;
          check(g_regs == pack_exp(), "R6", "generic copies", g_regs, pack_exp());
          if (i == 0) check(g_enable == v[1], "R7", "enable", g_enable, v[1]);
          if (i == 0) check(g_regs[2*DW-1:DW] == exp_g[1], "R8", "zero reset bit keeps data",
                            g_regs[2*DW-1:DW], exp_g[1]);
          bus_xfer(1'b0, AW'(i), '0, rd, w, ta);
          check(rd == v && w == 0, "R6", "readback", rd, v);
        end
      end
    end

    // R5 stall on busy register
    g_half = 9.35;
    bus_xfer(1'b1, 3'd2, 8'h11, rd, w, ta);
    bus_xfer(1'b0, 3'd2, '0, rd, w, ta);
    check(w > 0 && rd == 8'h11, "R5", "read stalled", {rd, 8'(w)}, 8'h11);
    check(sync_busy[2] == 1'b0, "R5", "busy clear at completion", sync_busy[2], 0);
    bus_xfer(1'b1, 3'd2, 8'h22, rd, w, ta);
    bus_xfer(1'b1, 3'd2, 8'h44, rd, w, ta);
    check(w > 0, "R5", "write stalled", w, 1);
    wait_idle(2, tb);
    check_delay(ta, tb, "held write");
    exp_g[2] = 8'h44;
    #1;
    check(g_regs == pack_exp(), "R5", "held write value", g_regs, pack_exp());
    repeat (40) @(negedge bus_clk);
    check(sync_busy == '0, "R5", "single launch", sync_busy, 0);

    // R9 R10 software reset
    bus_xfer(1'b1, 3'd1, 8'hA5, rd, w, ta); wait_idle(1, tb);
    bus_xfer(1'b1, 3'd2, 8'h3C, rd, w, ta); wait_idle(2, tb);
    bus_xfer(1'b1, 3'd0, 8'h02, rd, w, ta); wait_idle(0, tb);
    #1;
    check(g_enable == 1'b1, "R7", "enable set", g_enable, 1);
    bus_xfer(1'b1, 3'd0, 8'h03, rd, w, ta);
    bus_xfer(1'b0, AW'(NREG), '0, rd, w, ta);
    check(rd[0] == 1'b1 && w == 0, "R10", "status during reset", {rd, 8'(w)}, 16'h0100);
    bus_xfer(1'b0, 3'd2, '0, rd, w, ta);
    check(w > 0, "R10", "register stalled during reset", w, 1);
    check(rd == '0, "R9", "register cleared", rd, 0);
    check(sync_busy[0] == 1'b0, "R9", "reset busy cleared", sync_busy[0], 0);
    check(g_regs == '0 && g_enable == 1'b0, "R9", "generic cleared", g_regs, 0);
    bus_xfer(1'b0, 3'd0, '0, rd, w, ta);
    check(rd == '0, "R9", "control self-cleared", rd, 0);

    // R11 data write racing a software reset
    foreach (periods[p]) begin
      g_half = periods[p] * 1.7;
      repeat (3) @(negedge bus_clk);
      bus_xfer(1'b1, 3'd1, 8'h77, rd, w, ta);
      bus_xfer(1'b1, 3'd0, 8'h01, rd, w, ta);
      wait_idle(0, tb);
      wait_idle(1, tb);
      #1;
      check(g_regs == '0, "R11", "race generic", g_regs, 0);
      bus_xfer(1'b0, 3'd1, '0, rd, w, ta);
      check(rd == '0, "R11", "race readback", rd, 0);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule